// File: doc/BRIEF.md
# ECC Error Address Log

This block keeps a short history of the memory locations at which error-correcting-code checks failed. Software reads this history back later. It holds three independent logs: one for single-bit (corrected) errors, one for double-bit (uncorrectable) errors and one for address errors. Each log is a four-entry first-in first-out store of 18-bit addresses, counted in 128-bit units. All three logs see a shared error address. A one-hot strobe vector says which log or logs record it.

Software reads each log through a 19-bit status word. That word carries the oldest logged address and a flag that is set whenever the log holds anything. Every status read removes the entry it returned, so a loop of reads drains the log. A write-one clear strobe per log empties that log at once. One shared control bit decides whether an address already held in a log may be stored again. The log keeps the earliest errors: once a log is full, later addresses are lost rather than overwriting older ones.

Top module: `ecc_err_addr_log`

## Requirements
- R1: Each log holds at most four entries, and each entry keeps a full 18-bit address, including the value 0x3FFFF.
- R2: When a log is full and is not read in the same cycle, an error strobe for that log leaves its contents unchanged, so the first four addresses survive.
- R3: Successive reads return addresses in the order in which their errors arrived, oldest first.
- R4: While the discard-duplicates bit is 1, an address equal to any entry the log holds is not stored again. This includes an entry being read out in that same cycle.
- R5: While the discard-duplicates bit is 0, every error strobe stores its address, repeats included.
- R6: Status word bits 17:0 show the oldest address and bit 18 is 1 exactly when the log is not empty; when empty, bits 17:0 read zero.
- R7: A read strobe on a non-empty log removes the oldest entry one cycle later.
- R8: A clear strobe empties its log, and it overrides an error strobe or read strobe to that log in the same cycle.
- R9: When a full log receives a read strobe and an error strobe in the same cycle, the oldest entry leaves and the new address is stored in the freed place.
- R10: A read strobe on an empty log changes nothing, and the status word stays at zero.
- R11: After reset all logs are empty and the discard-duplicates bit is 1; a configuration write loads that bit from `cfgDiscardDup`.
- R12: Index 0 of the error, read and clear strobe vectors and of the status array belongs to the single-bit log, index 1 to the double-bit log and index 2 to the address-error log; the logs do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errStb | input | 3 | Per-log error detected strobe (0 single, 1 double, 2 address) |
| errAddr | input | 18 | Address of the failing access in 128-bit units |
| cfgWrEn | input | 1 | Loads the discard-duplicates bit |
| cfgDiscardDup | input | 1 | New discard-duplicates value, taken when cfgWrEn is 1 |
| clrStb | input | 3 | Per-log write-one clear |
| rdStb | input | 3 | Per-log status read strobe; pops the entry shown |
| statusWord | output | 3x19 | Per-log status: bit 18 valid, bits 17:0 oldest address |

## Verification
The bench builds the block with its default parameters: three logs, each four entries deep with 18-bit addresses. With only four entries, a few strobes are enough to fill a log, overflow it, and pop from it at full occupancy. Seven-entry sequences therefore reach the drop path, the simultaneous read-and-store path and the duplicate check against a departing entry. The 18-bit width lets the all-ones address be checked at full width.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned DefDepth   = 4;
  localparam int unsigned DefAddrW   = 18;
  localparam int unsigned DefNumLogs = 3;

  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
  } logCtrl_t;
endpackage

// File: rtl/ecc_log_dp.sv
module ecc_log_dp
  import ecc_log_pkg::*;
#(
  parameter int unsigned Depth = DefDepth,
  parameter int unsigned AddrW = DefAddrW,
  localparam int unsigned CntW = $clog2(Depth + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logCtrl_t         ctrl,
  input  logic [AddrW-1:0] pushAddr,
  output logic [AddrW-1:0] headAddr,
  output logic [CntW-1:0]  count,
  output logic             dupHit
);
  logic [AddrW-1:0] entry     [Depth];
  logic [AddrW-1:0] shifted   [Depth];
  logic [AddrW-1:0] nextEntry [Depth];
  logic [CntW-1:0]  wrIdx;

  // next value of each slot when the head leaves
  for (genvar gi = 0; gi < Depth; gi++) begin : gShift
    if (gi == Depth - 1) begin : gLast
      assign shifted[gi] = '0;
    end else begin : gMid
      assign shifted[gi] = entry[gi+1];
    end
  end

  assign wrIdx = ctrl.pop ? count - 1'b1 : count;

  always_comb begin
    for (int i = 0; i < Depth; i++) begin
      nextEntry[i] = ctrl.pop ? shifted[i] : entry[i];
      if (ctrl.push && (CntW'(i) == wrIdx)) nextEntry[i] = pushAddr;
    end
  end

  always_comb begin
    dupHit = 1'b0;
    for (int i = 0; i < Depth; i++) begin
      if ((CntW'(i) < count) && (entry[i] == pushAddr)) dupHit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      count <= '0;
      for (int i = 0; i < Depth; i++) entry[i] <= '0;
    end else begin
      count <= count + CntW'(ctrl.push) - CntW'(ctrl.pop);
      for (int i = 0; i < Depth; i++) entry[i] <= nextEntry[i];
    end
  end

  assign headAddr = entry[0];
endmodule

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
#(
  parameter int unsigned Depth = DefDepth,
  localparam int unsigned CntW = $clog2(Depth + 1)
) (
  input  logic            errIn,
  input  logic            rdIn,
  input  logic            clrIn,
  input  logic            discardDup,
  input  logic            dupHit,
  input  logic [CntW-1:0] count,
  output logCtrl_t        ctrl
);
  logic notEmpty;
  logic isFull;
  logic suppress;

  assign notEmpty = (count != '0);
  assign isFull   = (count == CntW'(Depth));
  assign suppress = discardDup && dupHit;

  always_comb begin
    ctrl.clear = clrIn;
    ctrl.pop   = rdIn && notEmpty && !clrIn;
    ctrl.push  = errIn && !clrIn && !suppress && (!isFull || ctrl.pop);
  end
endmodule

// File: rtl/ecc_err_addr_log.sv
module ecc_err_addr_log
  import ecc_log_pkg::*;
#(
  parameter int unsigned NumLogs = DefNumLogs,
  parameter int unsigned Depth   = DefDepth,
  parameter int unsigned AddrW   = DefAddrW,
  localparam int unsigned CntW   = $clog2(Depth + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NumLogs-1:0]              errStb,
  input  logic [AddrW-1:0]                errAddr,
  input  logic                            cfgWrEn,
  input  logic                            cfgDiscardDup,
  input  logic [NumLogs-1:0]              clrStb,
  input  logic [NumLogs-1:0]              rdStb,
  output logic [NumLogs-1:0][AddrW:0]     statusWord
);
  logic discardDup;
  logic [NumLogs-1:0][CntW-1:0] logCount;

  always_ff @(posedge clk) begin
    if (!rstN)        discardDup <= 1'b1;
    else if (cfgWrEn) discardDup <= cfgDiscardDup;
  end

  for (genvar g = 0; g < NumLogs; g++) begin : gLog
    logCtrl_t         ctrl;
    logic             dupHit;
    logic [AddrW-1:0] headAddr;
    logic             hasData;

    ecc_log_ctrl #(.Depth(Depth)) u_ctrl (
      .errIn(errStb[g]), .rdIn(rdStb[g]), .clrIn(clrStb[g]),
      .discardDup(discardDup), .dupHit(dupHit),
      .count(logCount[g]), .ctrl(ctrl)
    );

    ecc_log_dp #(.Depth(Depth), .AddrW(AddrW)) u_dp (
      .clk(clk), .rstN(rstN), .ctrl(ctrl), .pushAddr(errAddr),
      .headAddr(headAddr), .count(logCount[g]), .dupHit(dupHit)
    );

    assign hasData       = (logCount[g] != '0);
    assign statusWord[g] = {hasData, hasData ? headAddr : {AddrW{1'b0}}};
  end
endmodule

// File: rtl/ecc_log_chk.sv
module ecc_log_chk #(
  parameter int unsigned NumLogs = 3,
  parameter int unsigned Depth   = 4,
  parameter int unsigned AddrW   = 18,
  localparam int unsigned CntW   = $clog2(Depth + 1)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NumLogs-1:0]          errStb,
  input logic [NumLogs-1:0]          clrStb,
  input logic [NumLogs-1:0]          rdStb,
  input logic [NumLogs-1:0][AddrW:0] statusWord,
  input logic [NumLogs-1:0][CntW-1:0] logCount
);
  for (genvar g = 0; g < NumLogs; g++) begin : gChk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      logCount[g] <= CntW'(Depth)); // R1
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
      (logCount[g] == CntW'(Depth) && !rdStb[g] && !clrStb[g])
      |=> (logCount[g] == CntW'(Depth)) && $stable(statusWord[g])); // R2
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !statusWord[g][AddrW] |-> (statusWord[g][AddrW-1:0] == '0)); // R6
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rstN)
      (rdStb[g] && logCount[g] != '0 && !errStb[g] && !clrStb[g])
      |=> logCount[g] == $past(logCount[g]) - 1'b1); // R7
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
      clrStb[g] |=> !statusWord[g][AddrW]); // R8
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rstN)
      (rdStb[g] && errStb[g] && !clrStb[g] && logCount[g] == CntW'(Depth))
      |=> statusWord[g][AddrW]); // R9
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
      (logCount[g] == '0 && !errStb[g] && !clrStb[g])
      |=> logCount[g] == '0); // R10
  end
endmodule

bind ecc_err_addr_log ecc_log_chk #(.NumLogs(NumLogs), .Depth(Depth), .AddrW(AddrW)) u_chk (
  .clk(clk), .rstN(rstN), .errStb(errStb), .clrStb(clrStb), .rdStb(rdStb),
  .statusWord(statusWord), .logCount(logCount)
);

// File: tb/test_ecc_err_addr_log.sv
`timescale 1ns/100ps
module test_ecc_err_addr_log;
  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       errStb = '0;
  logic [17:0]      errAddr = '0;
  logic             cfgWrEn = 1'b0;
  logic             cfgDiscardDup = 1'b0;
  logic [2:0]       clrStb = '0;
  logic [2:0]       rdStb = '0;
  logic [2:0][18:0] statusWord;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecc_err_addr_log i_ecc_err_addr_log (
    .clk(clk), .rstN(rstN), .errStb(errStb), .errAddr(errAddr),
    .cfgWrEn(cfgWrEn), .cfgDiscardDup(cfgDiscardDup),
    .clrStb(clrStb), .rdStb(rdStb), .statusWord(statusWord)
  );

  // fields: err[45:43] addr[42:25] rd[24:22] clr[21:19] expected log0 status[18:0]
  localparam int NVec = 12;
  localparam logic [45:0] VecTab [NVec] = '{
    {3'b001, 18'h00010, 3'b000, 3'b000, 19'h40010}, // first entry
    {3'b001, 18'h00020, 3'b000, 3'b000, 19'h40010},
    {3'b001, 18'h00010, 3'b000, 3'b000, 19'h40010}, // duplicate suppressed
    {3'b001, 18'h00030, 3'b000, 3'b000, 19'h40010},
    {3'b001, 18'h00040, 3'b000, 3'b000, 19'h40010}, // now full
    {3'b001, 18'h00050, 3'b000, 3'b000, 19'h40010}, // dropped
    {3'b000, 18'h00000, 3'b001, 3'b000, 19'h40020},
    {3'b001, 18'h00050, 3'b001, 3'b000, 19'h40030}, // read + store
    {3'b000, 18'h00000, 3'b001, 3'b000, 19'h40040},
    {3'b000, 18'h00000, 3'b001, 3'b000, 19'h40050},
    {3'b000, 18'h00000, 3'b001, 3'b000, 19'h00000},
    {3'b000, 18'h00000, 3'b001, 3'b000, 19'h00000}  // empty read
  };

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, return at the next falling edge
  task automatic step(input logic [2:0] e, input logic [17:0] a,
                      input logic [2:0] r, input logic [2:0] c);
    errStb = e; errAddr = a; rdStb = r; clrStb = c;
    @(negedge clk);
    errStb = '0; errAddr = '0; rdStb = '0; clrStb = '0;
  endtask

  task automatic setDiscard(input logic v);
    cfgWrEn = 1'b1; cfgDiscardDup = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state of all logs
    for (int i = 0; i < 3; i++) check("R11 reset empty", statusWord[i], 19'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk on the single-bit log, discard bit at its reset value 1 (R11)
    for (int k = 0; k < NVec; k++) begin
      step(VecTab[k][45:43], VecTab[k][42:25], VecTab[k][24:22], VecTab[k][21:19]);
      check("table R1 R2 R3 R4 R6 R7 R9 R10 R11", statusWord[0], VecTab[k][18:0]);
    end

    // R12 double-bit log at index 1, others untouched
    step(3'b010, 18'h00111, 3'b000, 3'b000);
    check("R12 double log", statusWord[1], 19'h40111);
    check("R12 single untouched", statusWord[0], 19'h0);
    check("R12 addr untouched", statusWord[2], 19'h0);
    step(3'b100, 18'h00222, 3'b000, 3'b000);
    check("R12 addr log", statusWord[2], 19'h40222);
    step(3'b000, 18'h0, 3'b000, 3'b010); // R8 clear bit 1
    check("R8 clear bit1", statusWord[1], 19'h0);
    check("R8 clear bit1 spares addr log", statusWord[2], 19'h40222);
    step(3'b000, 18'h0, 3'b000, 3'b100);
    check("R8 clear bit2", statusWord[2], 19'h0);

    // R5 repeats stored when discard bit is 0
    setDiscard(1'b0);
    step(3'b001, 18'h00005, 3'b000, 3'b000);
    step(3'b001, 18'h00005, 3'b000, 3'b000);
    step(3'b000, 18'h0, 3'b001, 3'b000);
    check("R5 repeat kept", statusWord[0], 19'h40005);
    step(3'b000, 18'h0, 3'b001, 3'b000);
    check("R5 drained", statusWord[0], 19'h0);

    // R4 duplicate of the entry being popped is still suppressed
    setDiscard(1'b1);
    step(3'b001, 18'h00007, 3'b000, 3'b000);
    step(3'b001, 18'h00007, 3'b001, 3'b000);
    check("R4 dup vs popped entry", statusWord[0], 19'h0);

    // R9 full log, read and store together, then drain for order (R3)
    for (int i = 1; i <= 4; i++) step(3'b001, 18'(i), 3'b000, 3'b000);
    step(3'b001, 18'h00009, 3'b001, 3'b000);
    check("R9 head after swap", statusWord[0], 19'h40002);
    step(3'b000, 18'h0, 3'b001, 3'b000);
    check("R3 order", statusWord[0], 19'h40003);
    step(3'b000, 18'h0, 3'b001, 3'b000);
    check("R3 order", statusWord[0], 19'h40004);
    step(3'b000, 18'h0, 3'b001, 3'b000);
    check("R9 new address stored", statusWord[0], 19'h40009);
    step(3'b000, 18'h0, 3'b001, 3'b000);
    check("R10 empty after drain", statusWord[0], 19'h0);

    // R8 clear wins over a store in the same cycle
    step(3'b001, 18'h0000A, 3'b000, 3'b000);
    step(3'b001, 18'h0000B, 3'b001, 3'b001);
    check("R8 clear priority", statusWord[0], 19'h0);

    // R1 full-width address
    step(3'b001, 18'h3FFFF, 3'b000, 3'b000);
    check("R1 full width", statusWord[0], 19'h7FFFF);
    step(3'b000, 18'h0, 3'b001, 3'b000);
    check("R7 pop", statusWord[0], 19'h0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule